// File: doc/BRIEF.md
# Funnel Left Shifter with Flag Generation

This block carries out a double-width left shift for an integer execution pipe. A destination operand of 16, 32 or 64 bits is moved toward its most significant end by a shift amount. The low positions it vacates are filled from the most significant bits of a second source operand. The block therefore behaves as a funnel: it joins the two operands, shifts the joined value and keeps the upper half.

Alongside the result it produces the arithmetic status bits a flags register expects: carry, overflow, sign, zero and parity. It also gives a write-enable that tells the flags register whether to take them. The pipe pulses `start_i` with all operands valid. One clock later the registered result and flags appear together with a one-cycle `done_o`. They hold until the next start.

Top module: `fsh_dbl_left`

## Requirements
- R1: `size_i` picks the operand width: 0 is 16 bits, 1 is 32 bits, 2 and 3 are 64 bits. The 8-bit raw count keeps its low 5 bits for the 16 and 32 bit widths and its low 6 bits for the 64-bit width. All other count bits are ignored.
- R2: For a nonzero masked count within the width, the result is the upper W bits of the 2W-bit value {dst, src} shifted left by the count. Bits of `result_o` above the selected width are zero.
- R3: For a masked count c with 1 <= c <= W, the carry bit is dst[W-c], which is the last bit pushed out of the destination.
- R4: With a masked count of zero, `result_o` equals the destination truncated to the width, `flags_o` equals `flags_i` unchanged, and `flag_we_o` stays low.
- R5: With a masked count of exactly one, overflow is 1 when the result's top bit (bit W-1) differs from the destination's top bit, and 0 otherwise.
- R6: For a nonzero count, sign is result bit W-1 and zero is 1 when the result is all zeros. Parity is 1 when the low byte of the result holds an even number of ones. In `flags_o`/`flags_i`, bit 0 is carry, bit 1 parity, bit 2 zero, bit 3 sign and bit 4 overflow.
- R7: `done_o` is high exactly in the cycle after a cycle with `start_i` high. `flag_we_o` is high only in such a cycle, and only when the masked count was nonzero.
- R8: While `rst` is high, the next clock clears `done_o`, `flag_we_o`, `result_o` and `flags_o` to zero.
- R9: `result_o` and `flags_o` keep their values through cycles without `start_i`, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Operands valid, begin an operation |
| size_i | input | 2 | Operand width select |
| dst_i | input | 64 | Operand that is shifted |
| src_i | input | 64 | Operand supplying the fill bits |
| cnt_i | input | 8 | Raw shift count |
| flags_i | input | 5 | Incoming status bits |
| result_o | output | 64 | Shifted result, zero-extended |
| flags_o | output | 5 | Outgoing status bits |
| flag_we_o | output | 1 | Status bits should be written |
| done_o | output | 1 | Result valid pulse |

## Verification
Every output of this block comes from a single register stage, so the result, the flags, `flag_we_o` and `done_o` are all due on the first rising edge after the edge that sampled `start_i`. The bench drives a start on a falling edge and drops it on the next falling edge. It compares all outputs at that falling edge, half a period after the capture. One falling edge later it checks that `done_o` and `flag_we_o` have fallen and that result and flags held, even though the inputs were scrambled in between. Outputs that are undefined for a given count are left unchecked: overflow for counts above one, and result, carry, sign, zero and parity for counts beyond a 16-bit width.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int unsigned DATA_W    = 64;
    localparam int unsigned RAW_CNT_W = 8;
    localparam int unsigned SHAMT_W   = $clog2(DATA_W);
    localparam int unsigned NUM_LANES = 3;
    localparam int unsigned FLAGS_W   = 5;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_64B = 2'd3
    } size_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic pf;
        logic cf;
    } flags_t;

    function automatic int unsigned lane_idx(size_e s);
        case (s)
            SZ_16:   return 0;
            SZ_32:   return 1;
            default: return 2;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(size_e s);
        case (s)
            SZ_16:   return DATA_W'(16'hFFFF);
            SZ_32:   return DATA_W'(32'hFFFF_FFFF);
            default: return '1;
        endcase
    endfunction

    function automatic logic [SHAMT_W-1:0] mask_count(size_e s, logic [RAW_CNT_W-1:0] raw);
        case (s)
            SZ_16, SZ_32: return SHAMT_W'(raw[SHAMT_W-2:0]);
            default:      return raw[SHAMT_W-1:0];
        endcase
    endfunction

    function automatic logic top_bit(size_e s, logic [DATA_W-1:0] v);
        case (s)
            SZ_16:   return v[15];
            SZ_32:   return v[31];
            default: return v[DATA_W-1];
        endcase
    endfunction

    function automatic logic even_ones(logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/fsh_count_mask.sv
module fsh_count_mask
    import fsh_pkg::*;
(
    input  size_e                  size_i,
    input  logic [RAW_CNT_W-1:0]   raw_i,
    output logic [SHAMT_W-1:0]     amt_o,
    output logic                   amt_zero_o,
    output logic                   amt_one_o
);
    logic unused_hi;
    assign unused_hi  = ^raw_i[RAW_CNT_W-1:SHAMT_W];

    assign amt_o      = mask_count(size_i, raw_i);
    assign amt_zero_o = (amt_o == '0);
    assign amt_one_o  = (amt_o == SHAMT_W'(1));
endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel
    import fsh_pkg::*;
(
    input  size_e                size_i,
    input  logic [DATA_W-1:0]    dst_i,
    input  logic [DATA_W-1:0]    src_i,
    input  logic [SHAMT_W-1:0]   amt_i,
    output logic [DATA_W-1:0]    res_o,
    output logic                 cf_o
);
    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic [NUM_LANES-1:0] lane_cf;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int unsigned W = 16 << i;
        logic [2*W:0] joined;
        always_comb begin
            joined = {1'b0, dst_i[W-1:0], src_i[W-1:0]} << amt_i;
        end
        assign lane_res[i] = DATA_W'(joined[2*W-1:W]);
        assign lane_cf[i]  = joined[2*W];
    end

    always_comb begin
        res_o = lane_res[lane_idx(size_i)];
        cf_o  = lane_cf[lane_idx(size_i)];
    end
endmodule

// File: rtl/fsh_flag_gen.sv
module fsh_flag_gen
    import fsh_pkg::*;
(
    input  size_e              size_i,
    input  logic               dst_top_i,
    input  logic [DATA_W-1:0]  res_i,
    input  logic               cf_i,
    input  logic               amt_zero_i,
    input  logic               amt_one_i,
    input  flags_t             flags_i,
    output flags_t             flags_o,
    output logic               we_o
);
    flags_t computed;

    always_comb begin
        computed.cf = cf_i;
        computed.sf = top_bit(size_i, res_i);
        computed.zf = (res_i == '0);
        computed.pf = even_ones(res_i[7:0]);
        computed.of = amt_one_i ? (computed.sf ^ dst_top_i) : 1'b0;
    end

    assign flags_o = amt_zero_i ? flags_i : computed;
    assign we_o    = ~amt_zero_i;
endmodule

// File: rtl/fsh_dbl_left.sv
module fsh_dbl_left
    import fsh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [1:0]           size_i,
    input  logic [DATA_W-1:0]    dst_i,
    input  logic [DATA_W-1:0]    src_i,
    input  logic [RAW_CNT_W-1:0] cnt_i,
    input  logic [FLAGS_W-1:0]   flags_i,
    output logic [DATA_W-1:0]    result_o,
    output logic [FLAGS_W-1:0]   flags_o,
    output logic                 flag_we_o,
    output logic                 done_o
);
    size_e              size;
    logic [SHAMT_W-1:0] amt;
    logic               amt_zero;
    logic               amt_one;
    logic [DATA_W-1:0]  res_n;
    logic               cf_n;
    flags_t             flags_n;
    logic               we_n;

    flags_t             flags_q;
    logic [DATA_W-1:0]  res_q;
    logic               we_q;
    logic               done_q;

    assign size = size_e'(size_i);

    fsh_count_mask u_mask (
        .size_i     (size),
        .raw_i      (cnt_i),
        .amt_o      (amt),
        .amt_zero_o (amt_zero),
        .amt_one_o  (amt_one)
    );

    fsh_funnel u_funnel (
        .size_i (size),
        .dst_i  (dst_i),
        .src_i  (src_i),
        .amt_i  (amt),
        .res_o  (res_n),
        .cf_o   (cf_n)
    );

    fsh_flag_gen u_flags (
        .size_i     (size),
        .dst_top_i  (top_bit(size, dst_i)),
        .res_i      (res_n),
        .cf_i       (cf_n),
        .amt_zero_i (amt_zero),
        .amt_one_i  (amt_one),
        .flags_i    (flags_t'(flags_i)),
        .flags_o    (flags_n),
        .we_o       (we_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
            we_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= start_i;
            we_q   <= start_i & we_n;
            if (start_i) begin
                res_q   <= res_n;
                flags_q <= flags_n;
            end
        end
    end

    assign result_o  = res_q;
    assign flags_o   = flags_q;
    assign flag_we_o = we_q;
    assign done_o    = done_q;
endmodule

// File: rtl/fsh_dbl_left_chk.sv
module fsh_dbl_left_chk
    import fsh_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic [1:0]           size_i,
    input logic [DATA_W-1:0]    dst_i,
    input logic [RAW_CNT_W-1:0] cnt_i,
    input logic [FLAGS_W-1:0]   flags_i,
    input logic [DATA_W-1:0]    result_o,
    input logic [FLAGS_W-1:0]   flags_o,
    input logic                 flag_we_o,
    input logic                 done_o
);
    logic [SHAMT_W-1:0] chk_amt;
    assign chk_amt = mask_count(size_e'(size_i), cnt_i);

    assert_done_after_start_R7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o);

    assert_we_within_done_R7: assert property (@(posedge clk) disable iff (rst)
        flag_we_o |-> done_o);

    assert_zero_count_passthru_R4: assert property (@(posedge clk) disable iff (rst)
        (start_i && chk_amt == '0) |=>
            (!flag_we_o && flags_o == $past(flags_i)
             && result_o == ($past(dst_i) & width_mask(size_e'($past(size_i))))));

    assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> ((result_o & ~width_mask(size_e'($past(size_i)))) == '0));

    assert_overflow_count_one_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && chk_amt == SHAMT_W'(1)) |=>
            (flags_o[4] == (top_bit(size_e'($past(size_i)), result_o)
                            ^ top_bit(size_e'($past(size_i)), $past(dst_i)))));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
        flag_we_o |-> (flags_o[2] == (result_o == '0)));

    assert_parity_flag_R6: assert property (@(posedge clk) disable iff (rst)
        flag_we_o |-> (flags_o[1] == ~^result_o[7:0]));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(result_o) && $stable(flags_o)));

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!done_o && !flag_we_o && result_o == '0 && flags_o == '0));
endmodule

bind fsh_dbl_left fsh_dbl_left_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .size_i    (size_i),
    .dst_i     (dst_i),
    .cnt_i     (cnt_i),
    .flags_i   (flags_i),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .flag_we_o (flag_we_o),
    .done_o    (done_o)
);

// File: tb/tb_fsh_dbl_left.sv
`timescale 1ns/1ps
module tb_fsh_dbl_left;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic [63:0] dst_i = '0;
    logic [63:0] src_i = '0;
    logic [7:0]  cnt_i = '0;
    logic [4:0]  flags_i = '0;
    logic [63:0] result_o;
    logic [4:0]  flags_o;
    logic        flag_we_o;
    logic        done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fsh_dbl_left dut (
        .clk(clk), .rst(rst), .start_i(start_i), .size_i(size_i),
        .dst_i(dst_i), .src_i(src_i), .cnt_i(cnt_i), .flags_i(flags_i),
        .result_o(result_o), .flags_o(flags_o), .flag_we_o(flag_we_o),
        .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_reset();
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done after reset", 64'(done_o), 64'd0);
        chk(flag_we_o == 1'b0, "R8", "flag_we after reset", 64'(flag_we_o), 64'd0);
        chk(result_o == '0, "R8", "result after reset", result_o, 64'd0);
        chk(flags_o == '0, "R8", "flags after reset", 64'(flags_o), 64'd0);
    endtask

    // One operation: model, drive, check at due cycle, then check pulse end and hold.
    task automatic run_op(input logic [1:0] sz, input logic [63:0] d, input logic [63:0] s,
                          input logic [7:0] c, input logic [4:0] fin, input string req);
        int unsigned w, cm;
        logic [63:0] m, dd, ss, exp_res;
        logic [4:0]  exp_fl;
        logic        exp_we, cf, undef;
        logic [63:0] held_res;
        logic [4:0]  held_fl;
        w  = (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
        m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        cm = (w == 64) ? int'(c & 8'h3F) : int'(c & 8'h1F);
        undef = (cm > w);
        cf = 1'b0;
        if (cm == 0) begin
            exp_res = d & m;
            exp_fl  = fin;
            exp_we  = 1'b0;
        end else begin
            dd = d & m;
            ss = s & m;
            for (int k = 0; k < cm; k++) begin
                cf = dd[w-1];
                dd = ((dd << 1) | 64'(ss[w-1])) & m;
                ss = (ss << 1) & m;
            end
            exp_res   = dd;
            exp_fl[0] = cf;
            exp_fl[1] = ~^dd[7:0];
            exp_fl[2] = (dd == 0);
            exp_fl[3] = dd[w-1];
            exp_fl[4] = (cm == 1) ? (dd[w-1] ^ d[w-1]) : 1'b0;
            exp_we    = 1'b1;
        end

        @(negedge clk);
        size_i = sz; dst_i = d; src_i = s; cnt_i = c; flags_i = fin; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b1, "R7", {req, " done due"}, 64'(done_o), 64'd1);
        chk(flag_we_o == exp_we, {req, "/R7"}, "flag_we", 64'(flag_we_o), 64'(exp_we));
        if (!undef) begin
            chk(result_o == exp_res, req, "result", result_o, exp_res);
            chk(flags_o[0] == exp_fl[0], {req, "/R3"}, "carry", 64'(flags_o[0]), 64'(exp_fl[0]));
            chk(flags_o[3:1] == exp_fl[3:1], {req, "/R6"}, "sign/zero/parity",
                64'(flags_o[3:1]), 64'(exp_fl[3:1]));
            if (cm <= 1)
                chk(flags_o[4] == exp_fl[4], {req, "/R5"}, "overflow",
                    64'(flags_o[4]), 64'(exp_fl[4]));
        end
        held_res = result_o;
        held_fl  = flags_o;
        // scramble inputs while idle: must have no effect (R9)
        dst_i = ~d; src_i = ~s; cnt_i = 8'd1; flags_i = ~fin; size_i = ~sz;
        @(negedge clk);
        chk(done_o == 1'b0, "R7", {req, " done pulse ends"}, 64'(done_o), 64'd0);
        chk(flag_we_o == 1'b0, "R7", {req, " we pulse ends"}, 64'(flag_we_o), 64'd0);
        chk(result_o == held_res, "R9", {req, " result held"}, result_o, held_res);
        chk(flags_o == held_fl, "R9", {req, " flags held"}, 64'(flags_o), 64'(held_fl));
    endtask

    task automatic test_zero_counts();
        run_op(2'd0, 64'hFFFF_0000_0000_8001, 64'h1234, 8'h20, 5'b10101, "R4");
        run_op(2'd2, 64'hDEAD_BEEF_0123_4567, 64'h1, 8'h40, 5'b01010, "R4");
        run_op(2'd1, 64'h1111_2222_8765_4321, 64'h5, 8'h00, 5'b11111, "R4");
    endtask

    task automatic test_count_one();
        run_op(2'd0, 64'h4000, 64'h8000, 8'd1, 5'b0, "R5");
        run_op(2'd0, 64'hC000, 64'h0000, 8'd1, 5'b0, "R5");
        run_op(2'd2, 64'h8000_0000_0000_0001, 64'hF000_0000_0000_0000, 8'h41, 5'b0, "R5");
    endtask

    task automatic test_shifts();
        run_op(2'd0, 64'h1234, 64'hABCD, 8'd4, 5'b0, "R2");
        run_op(2'd1, 64'hFFFF_FFFF_1357_9BDF, 64'h8642_0ECA, 8'd31, 5'b0, "R2");
        run_op(2'd2, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 8'd63, 5'b0, "R3");
        run_op(2'd3, 64'hA5A5_5A5A_0F0F_F0F0, 64'h3C3C_C3C3_9696_6969, 8'd17, 5'b0, "R2");
        run_op(2'd0, 64'hFFFF_FFFF_FFFF_0F00, 64'h00F0, 8'd16, 5'b0, "R3");
    endtask

    task automatic test_flags();
        run_op(2'd1, 64'h8000_0000, 64'h0, 8'd1, 5'b0, "R6");
        run_op(2'd1, 64'h0000_00FF, 64'h0, 8'd8, 5'b0, "R6");
        run_op(2'd0, 64'h0007, 64'h0, 8'd1, 5'b0, "R6");
    endtask

    task automatic test_masking();
        run_op(2'd1, 64'h0000_0001, 64'hFFFF_FFFF, 8'h3F, 5'b0, "R1");
        run_op(2'd0, 64'h0F0F, 64'hF0F0, 8'hE3, 5'b0, "R1");
        run_op(2'd2, 64'h1, 64'h0, 8'hC5, 5'b0, "R1");
        run_op(2'd0, 64'h1234, 64'h5678, 8'd20, 5'b0, "R7");
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        check_reset();
        rst = 1'b0;
        test_zero_counts();
        test_count_one();
        test_shifts();
        test_flags();
        test_masking();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(done_o == 1'b0 && result_o == '0 && flags_o == '0, "R8", "mid-run reset",
            result_o, 64'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule